// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block turns a 32-bit virtual address into a 28-bit physical address through a small cache of page translations. Pages are 4 KiB. The upper twenty bits of the virtual address form the page number, and that page number is compared against the tag of every entry at once. The matching entry supplies a 16-bit frame number. The frame number is joined to the twelve offset bits, which pass through unchanged. Each entry also stores a valid bit and two access permissions, one for reads and one for writes. A lookup that matches an entry but asks for a forbidden access reports a protection fault and does not return an address.

Lookups are combinational from the stored table, so the answer for the current request appears in the same cycle. A fill port writes one new translation per clock edge. The fill goes into the lowest-numbered empty entry while one exists. Once the table is full, a round-robin pointer picks the entry to replace. A flush input empties the whole table at the next edge. Walking the page tables and deciding what to refill is left to the surrounding logic.

Top module: `xlate_buffer`

## Requirements
- R1: A lookup whose page number (lk_va[31:12]) equals the tag of a valid entry that permits the access asserts hit, and pa equals {stored frame number, lk_va[11:0]}, with the frame in pa[27:12].
- R2: A lookup that matches no valid entry asserts miss only, and pa is zero.
- R3: A lookup that matches a valid entry whose permission bit for the access is clear asserts fault only, and pa is zero. lk_write=1 requests a write and is checked against fill_wr. lk_write=0 requests a read and is checked against fill_rd.
- R4: While lk_valid is low, hit, miss and fault are all low.
- R5: After reset every entry is invalid, so every lookup misses.
- R6: A flush invalidates all entries at the next edge. A fill requested in the same cycle as a flush is dropped.
- R7: While empty entries remain, each fill occupies a distinct empty entry (the lowest-numbered one), so filling 64 distinct page numbers into an empty table keeps all 64 resident.
- R8: A fill into a full table replaces the entry named by a replacement pointer. The pointer is 0 after reset, advances by one after each such replacement, and wraps from 63 to 0.
- R9: A lookup made in the same cycle as a fill sees the table contents from before that fill.
- R10: At most one of hit, miss and fault is asserted in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_va | input | 32 | Virtual address to translate |
| lk_write | input | 1 | Access type: 1 write, 0 read |
| fill_en | input | 1 | Write a translation this cycle |
| fill_vpn | input | 20 | Page number (tag) of the new translation |
| fill_pfn | input | 16 | Frame number of the new translation |
| fill_rd | input | 1 | Read permitted for the new translation |
| fill_wr | input | 1 | Write permitted for the new translation |
| flush | input | 1 | Invalidate all entries |
| hit | output | 1 | Translation found and access permitted |
| miss | output | 1 | No valid matching entry |
| fault | output | 1 | Matching entry forbids the access |
| pa | output | 28 | Physical address, zero unless hit |

## Verification
Two situations put operations into the same cycle.

- **Fill and lookup together.** A fill can overwrite an entry that a lookup in the same cycle is reading. The bench fills a table completely, then issues a replacement fill while looking up the tag that is about to be evicted. It expects the old frame to come back with hit in that cycle, and a miss for that tag in the next cycle.
- **Flush and fill together.** Flush and fill can also coincide. The bench raises both together and expects the offered translation to be absent afterwards.

// File: rtl/xlate_buffer.sv
module xlate_buffer #(
  parameter int ENTRIES = 64,
  parameter int VA_W    = 32,
  parameter int PA_W    = 28,
  parameter int OFF_W   = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lk_valid,
  input  logic [VA_W-1:0]        lk_va,
  input  logic                   lk_write,
  input  logic                   fill_en,
  input  logic [VA_W-OFF_W-1:0]  fill_vpn,
  input  logic [PA_W-OFF_W-1:0]  fill_pfn,
  input  logic                   fill_rd,
  input  logic                   fill_wr,
  input  logic                   flush,
  output logic                   hit,
  output logic                   miss,
  output logic                   fault,
  output logic [PA_W-1:0]        pa
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PFN_W = PA_W - OFF_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q, rd_q, wr_q, match;
  logic [IDX_W-1:0]   rr_q, free_idx, victim;
  logic               found, perm_ok, full, do_fill;
  logic [PFN_W-1:0]   sel_pfn;

  wire [VPN_W-1:0] lk_vpn = lk_va[VA_W-1:OFF_W];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = vld_q[g] && (tag_q[g] == lk_vpn);
  end

  always_comb begin
    found   = 1'b0;
    perm_ok = 1'b0;
    sel_pfn = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        found   = 1'b1;
        perm_ok = lk_write ? wr_q[i] : rd_q[i];
        sel_pfn = pfn_q[i];
      end
    end
  end

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!vld_q[i]) free_idx = IDX_W'(i);
  end

  assign full    = &vld_q;
  assign victim  = full ? rr_q : free_idx;
  assign do_fill = fill_en && !flush;

  assign hit   = lk_valid && found && perm_ok;
  assign fault = lk_valid && found && !perm_ok;
  assign miss  = lk_valid && !found;
  assign pa    = hit ? {sel_pfn, lk_va[OFF_W-1:0]} : '0;

  always_ff @(posedge clk) begin
    if (do_fill) begin
      tag_q[victim] <= fill_vpn;
      pfn_q[victim] <= fill_pfn;
      rd_q[victim]  <= fill_rd;
      wr_q[victim]  <= fill_wr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      vld_q <= '0;
    end else if (do_fill) begin
      vld_q[victim] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (do_fill && full) begin
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (lk_valid -> miss));

  assert_fill_visible_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (do_fill && fill_rd) |=>
      ((lk_valid && !lk_write && lk_vpn == $past(fill_vpn)) ->
       (hit && pa[PA_W-1:OFF_W] == $past(fill_pfn))));

  assert_write_denied_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (do_fill && !fill_wr) |=>
      ((lk_valid && lk_write && lk_vpn == $past(fill_vpn)) -> (fault && pa == '0)));

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !(hit || miss || fault));

  assert_single_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit, miss, fault}));

  assert_reset_empty_R5: assert property (@(posedge clk)
    (rst_n && $past(!rst_n) && !$past(fill_en)) |-> (lk_valid -> miss));
endmodule

// File: tb/xlate_buffer_tb_top.sv
module xlate_buffer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0, lk_write = 1'b0;
  logic [31:0] lk_va = '0;
  logic        fill_en = 1'b0, fill_rd = 1'b0, fill_wr = 1'b0, flush = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [15:0] fill_pfn = '0;
  logic        hit, miss, fault;
  logic [27:0] pa;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  xlate_buffer dut_i (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_va(lk_va), .lk_write(lk_write),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_rd(fill_rd),
    .fill_wr(fill_wr), .flush(flush), .hit(hit), .miss(miss), .fault(fault), .pa(pa)
  );

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  task automatic expect_out(string req, logic eh, logic em, logic ef, logic [27:0] ep);
    checks++;
    if ({hit, miss, fault} !== {eh, em, ef} || pa !== ep) begin
      fails++;
      $display("FAIL %s: actual h/m/f=%b%b%b pa=%h expected h/m/f=%b%b%b pa=%h",
               req, hit, miss, fault, pa, eh, em, ef, ep);
    end
  endtask

  task automatic idle_cycle();
    @(posedge clk); #1;
    fill_en = 1'b0; flush = 1'b0; lk_valid = 1'b0;
  endtask

  task automatic fill(logic [19:0] vpn, logic [15:0] pfn, logic r, logic w);
    @(posedge clk); #1;
    lk_valid = 1'b0; flush = 1'b0;
    fill_en = 1'b1; fill_vpn = vpn; fill_pfn = pfn; fill_rd = r; fill_wr = w;
    @(posedge clk); #1;
    fill_en = 1'b0;
  endtask

  task automatic look(string req, logic [31:0] va, logic wr,
                      logic eh, logic em, logic ef, logic [27:0] ep);
    @(posedge clk); #1;
    lk_valid = 1'b1; lk_va = va; lk_write = wr;
    #2;
    expect_out(req, eh, em, ef, ep);
    @(posedge clk); #1;
    lk_valid = 1'b0;
  endtask

  task automatic do_flush();
    @(posedge clk); #1;
    flush = 1'b1;
    @(posedge clk); #1;
    flush = 1'b0;
  endtask

  task automatic t_reset();
    #1; #1; expect_out("R4", 0, 0, 0, '0);
    look("R5", 32'h1234_5678, 1'b0, 0, 1, 0, '0);
  endtask

  task automatic t_basic();
    fill(20'h12345, 16'hBEEF, 1'b1, 1'b0);
    look("R1", 32'h1234_5ABC, 1'b0, 1, 0, 0, {16'hBEEF, 12'hABC});
    look("R3", 32'h1234_5ABC, 1'b1, 0, 0, 1, '0);
    look("R2", 32'h1234_6ABC, 1'b0, 0, 1, 0, '0);
    fill(20'h00077, 16'h0042, 1'b0, 1'b1);
    look("R3", 32'h0007_7010, 1'b0, 0, 0, 1, '0);
    look("R1", 32'h0007_7010, 1'b1, 1, 0, 0, {16'h0042, 12'h010});
    lk_valid = 1'b0; #1; expect_out("R4", 0, 0, 0, '0);
  endtask

  task automatic t_flush();
    do_flush();
    look("R6", 32'h1234_5ABC, 1'b0, 0, 1, 0, '0);
    @(posedge clk); #1;
    flush = 1'b1; fill_en = 1'b1; fill_vpn = 20'h00ABC; fill_pfn = 16'h1111;
    fill_rd = 1'b1; fill_wr = 1'b1;
    idle_cycle();
    look("R6", 32'h00AB_C000, 1'b0, 0, 1, 0, '0);
  endtask

  task automatic t_fill_replace();
    do_flush();
    for (int i = 0; i < 64; i++) fill(20'(i + 16), 16'(i + 16'h100), 1'b1, 1'b1);
    for (int i = 0; i < 64; i++)
      look("R7", {20'(i + 16), 12'h004}, 1'b0, 1, 0, 0, {16'(i + 16'h100), 12'h004});
    @(posedge clk); #1;
    fill_en = 1'b1; fill_vpn = 20'h80000; fill_pfn = 16'hAAAA; fill_rd = 1'b1; fill_wr = 1'b1;
    lk_valid = 1'b1; lk_va = {20'd16, 12'h008}; lk_write = 1'b0;
    #2; expect_out("R9", 1, 0, 0, {16'h0100, 12'h008});
    idle_cycle();
    look("R8", {20'd16, 12'h0}, 1'b0, 0, 1, 0, '0);
    look("R8", {20'h80000, 12'h0}, 1'b0, 1, 0, 0, {16'hAAAA, 12'h0});
    look("R8", {20'd17, 12'h0}, 1'b0, 1, 0, 0, {16'h0101, 12'h0});
    fill(20'h80001, 16'hAAAB, 1'b1, 1'b1);
    look("R8", {20'd17, 12'h0}, 1'b0, 0, 1, 0, '0);
    for (int i = 2; i < 64; i++) fill(20'h80000 + 20'(i), 16'h2000 + 16'(i), 1'b1, 1'b1);
    fill(20'h90000, 16'h3333, 1'b1, 1'b1);
    look("R8", {20'h80000, 12'h0}, 1'b0, 0, 1, 0, '0);
    look("R8", {20'h80001, 12'h0}, 1'b0, 1, 0, 0, {16'hAAAB, 12'h0});
    look("R8", {20'h90000, 12'h5}, 1'b0, 1, 0, 0, {16'h3333, 12'h5});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_basic();
    t_flush();
    t_fill_replace();
    repeat (2) @(posedge clk);
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule